// File: doc/BRIEF.md
# EPP Host Cycle Engine

This block is the host-facing side of an enhanced parallel port. A small register bus (address, read and write strobes, write data, read data and a wait output) reaches three plain registers (port data, status, control) and five EPP ports. A host access to an EPP port runs a complete handshake on the 8-bit parallel bus using an active-low write line, an active-low data strobe, an active-low address strobe and the peripheral's active-low wait input. The host access is stalled on `hb_wait` until the handshake has ended.

The engine does not drive a strobe until the peripheral shows it is ready by pulling wait low. After the strobe, it waits for wait to return high before it ends the cycle. A watchdog, sized in clock cycles from a clock frequency and a time in microseconds, aborts a hung cycle and sets a sticky time-out flag. When no EPP cycle is active, the parallel pins follow the control register as a standard or bidirectional port.

Top module: `epp_host`

## Requirements
- R1: After reset the write line and both strobes are high, `hb_wait` is low, control and status read as 0, the bus is driven (`pd_oe`=1), and `strobe_n`, `autofd_n` and `init_n` are high.
- R2: With no EPP cycle active, `strobe_n`, `autofd_n` and `init_n` are the inverses of control bits 0, 1 and 2. `pd_oe` is the inverse of control bit 5 (direction, 1 = input). `pd_out` holds the last byte written at offset 0. Offset 0 reads the bus pins and offset 2 reads back the control byte.
- R3: With EPP enabled and direction 0, a write at offset 4, 5, 6 or 7 waits until wait is seen low. It then drives the byte with `pd_oe`=1 and the write line low, and only after that lowers the data strobe. The strobe is released once wait is seen high.
- R4: A write or read at offset 3 runs the same sequence on the address strobe. The data strobe stays high.
- R5: The host access is held with `hb_wait`=1 from the first cycle of an EPP access until the handshake ends, and for the whole time a strobe or the write line is asserted.
- R6: An EPP read keeps the write line high and the bus released while the strobe is low. It captures the bus as the strobe is released and returns that byte to the host.
- R7: If wait is not seen high within CLK_MHZ*TMO_US cycles of the start of a cycle, the strobe is released, the host access completes, and status bit 0 becomes 1. Writing status with bit 0 = 1 clears it; writing bit 0 = 0 leaves it set.
- R8: While control bit 0 (strobe) is 1, every EPP strobe phase has the write line low and the bus driven, whatever the access type.
- R9: A host write to an EPP port while direction bit 5 is 1 runs a read-style cycle: the write line stays high and the bus stays released. The time-out flag is not set and the offset-0 byte is not changed.
- R10: With EPP disabled, accesses at offsets 3 to 7 complete at once with no strobe, and writes there change nothing.
- R11: The data strobe and the address strobe are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| epp_en | input | 1 | Enables decoding of the EPP ports (offsets 3 to 7) |
| hb_addr | input | AW | Register offset of the host access |
| hb_wr | input | 1 | Host write request, held until `hb_wait` is low |
| hb_rd | input | 1 | Host read request, held until `hb_wait` is low |
| hb_wdata | input | DW | Host write data |
| hb_rdata | output | DW | Host read data, valid while `hb_wait` is low |
| hb_wait | output | 1 | Stalls the host access |
| pd_in | input | DW | Parallel bus pin levels |
| pd_out | output | DW | Parallel bus output byte |
| pd_oe | output | 1 | Parallel bus output enable |
| n_write | output | 1 | Active-low write line |
| n_dstb | output | 1 | Active-low data strobe |
| n_astb | output | 1 | Active-low address strobe |
| n_wait | input | 1 | Peripheral wait, active low |
| strobe_n | output | 1 | Standard-port strobe pin |
| autofd_n | output | 1 | Standard-port auto-feed pin |
| init_n | output | 1 | Standard-port init pin |

## Verification
The assertions check these rules on every cycle: the two strobes are never both low, the host is stalled whenever a strobe or the write line is active, the bus direction agrees with the write line during a strobe, the forced-write and direction-bit overrides hold, and the time-out flag rises only with the strobes released. The bench scenarios cover the rest. A peripheral model holds wait high for random stretches and acknowledges after random delays. It records whether a strobe fell before wait was low and whether the write line led the strobe. It also checks the transferred bytes, the addressing of each strobe, the time-out flag's set and clear rules, and the rule that writes are ignored when EPP is disabled or the direction bit is set.

// File: rtl/epp_host.sv
module epp_host #(
  parameter int CLK_MHZ = 50,
  parameter int TMO_US  = 10,
  parameter int DW      = 8,
  parameter int AW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          epp_en,
  input  logic [AW-1:0] hb_addr,
  input  logic          hb_wr,
  input  logic          hb_rd,
  input  logic [DW-1:0] hb_wdata,
  output logic [DW-1:0] hb_rdata,
  output logic          hb_wait,
  input  logic [DW-1:0] pd_in,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  output logic          n_write,
  output logic          n_dstb,
  output logic          n_astb,
  input  logic          n_wait,
  output logic          strobe_n,
  output logic          autofd_n,
  output logic          init_n
);
  localparam int TMO_CYC = CLK_MHZ * TMO_US;
  localparam int CW      = $clog2(TMO_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_SETUP, S_STB, S_DONE} st_t;

  st_t           st;
  logic [DW-1:0] dat_q, ctl_q, cap_q;
  logic          tmo_q, cyc_wr, cyc_adr;
  logic [1:0]    wsync;
  logic [CW-1:0] cnt;

  wire wt       = wsync[1];
  wire req      = hb_wr | hb_rd;
  wire epp_port = epp_en && (hb_addr >= AW'(3));
  wire start    = req && epp_port && (st == S_IDLE);
  wire busy     = (st == S_ARM) || (st == S_SETUP) || (st == S_STB);
  wire ack      = (st == S_STB) && wt;
  wire abort    = busy && !ack && (cnt == CW'(TMO_CYC - 1));
  wire drive_ph = (st == S_SETUP) || (st == S_STB);
  wire wr_eff   = (cyc_wr && !ctl_q[5]) || ctl_q[0];
  wire reg_we   = hb_wr && !epp_port;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wsync <= 2'b00;
    else        wsync <= {wsync[0], n_wait};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      cyc_wr  <= 1'b0;
      cyc_adr <= 1'b0;
      cap_q   <= '0;
    end else begin
      if (busy) cnt <= cnt + CW'(1);
      if (ack || abort) cap_q <= pd_in;
      if (abort) st <= S_DONE;
      else begin
        case (st)
          S_IDLE: if (start) begin
            st      <= S_ARM;
            cnt     <= '0;
            cyc_wr  <= hb_wr;
            cyc_adr <= (hb_addr == AW'(3));
          end
          S_ARM:   if (!wt) st <= S_SETUP;
          S_SETUP: st <= S_STB;
          S_STB:   if (wt) st <= S_DONE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      ctl_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      if (reg_we) begin
        case (hb_addr)
          AW'(0): dat_q <= hb_wdata;
          AW'(1): if (hb_wdata[0]) tmo_q <= 1'b0;
          AW'(2): ctl_q <= hb_wdata;
          default: ;
        endcase
      end
      if (start && hb_wr && !ctl_q[5]) dat_q <= hb_wdata;
      if (abort) tmo_q <= 1'b1;
    end
  end

  always_comb begin
    case (hb_addr)
      AW'(0):  hb_rdata = pd_in;
      AW'(1):  hb_rdata = {{(DW-1){1'b0}}, tmo_q};
      AW'(2):  hb_rdata = ctl_q;
      default: hb_rdata = epp_port ? cap_q : '0;
    endcase
  end

  assign hb_wait  = req && epp_port && (st != S_DONE);
  assign pd_out   = dat_q;
  assign pd_oe    = drive_ph ? wr_eff : !ctl_q[5];
  assign n_write  = !(drive_ph && wr_eff);
  assign n_dstb   = !((st == S_STB) && !cyc_adr);
  assign n_astb   = !((st == S_STB) && cyc_adr);
  assign strobe_n = !ctl_q[0];
  assign autofd_n = !ctl_q[1];
  assign init_n   = !ctl_q[2];
endmodule

module epp_host_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          hb_wr,
  input logic          hb_rd,
  input logic          hb_wait,
  input logic          pd_oe,
  input logic          n_write,
  input logic          n_dstb,
  input logic          n_astb,
  input logic [DW-1:0] ctl_q,
  input logic          tmo_q
);
  wire stb = !n_dstb || !n_astb;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!n_dstb && !n_astb)); // R11
  AST_STB_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> hb_wait); // R5
  AST_NWR_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    !n_write |-> ((hb_wr || hb_rd) && hb_wait)); // R5
  AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (pd_oe == !n_write)); // R3
  AST_FORCE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && ctl_q[0]) |-> (!n_write && pd_oe)); // R8
  AST_PCD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && ctl_q[5] && !ctl_q[0]) |-> (n_write && !pd_oe)); // R9
  AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> (n_dstb && n_astb && !hb_wait)); // R7
endmodule

bind epp_host epp_host_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_wait(hb_wait),
  .pd_oe(pd_oe), .n_write(n_write), .n_dstb(n_dstb), .n_astb(n_astb),
  .ctl_q(ctl_q), .tmo_q(tmo_q)
);

// File: tb/epp_host_tb.sv
module epp_host_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 4;
  localparam int TUS = 10;
  localparam int TMO = MHZ * TUS;

  logic       clk = 0, rst_n = 0, epp_en = 1;
  logic [2:0] hb_addr = 0;
  logic       hb_wr = 0, hb_rd = 0;
  logic [7:0] hb_wdata = 0, hb_rdata, pd_in, pd_out;
  logic       hb_wait, pd_oe, n_write, n_dstb, n_astb, strobe_n, autofd_n, init_n;
  logic       n_wait;

  int errors = 0, checks = 0;

  int   per_hold = 0, per_ack = 0;
  bit   per_hang = 0;
  logic [7:0] per_drive = 8'h00;

  int   hcnt, acnt;
  bit   acked, prev_nwr;
  bit   s_any, s_a, s_d, s_oe, s_nwr, s_pre_nwr, s_early, s_nostall, s_both;
  logic [7:0] s_dat;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pd_in = pd_oe ? pd_out : per_drive;

  epp_host #(.CLK_MHZ(MHZ), .TMO_US(TUS)) u_dut (
    .clk(clk), .rst_n(rst_n), .epp_en(epp_en), .hb_addr(hb_addr), .hb_wr(hb_wr),
    .hb_rd(hb_rd), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .hb_wait(hb_wait),
    .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe), .n_write(n_write),
    .n_dstb(n_dstb), .n_astb(n_astb), .n_wait(n_wait), .strobe_n(strobe_n),
    .autofd_n(autofd_n), .init_n(init_n));

  // peripheral model
  always @(posedge clk) begin
    if (!rst_n || !(hb_wr || hb_rd)) begin
      n_wait <= (per_hold != 0);
      hcnt <= 0; acnt <= 0; acked <= 0;
      s_any <= 0; s_a <= 0; s_d <= 0; s_oe <= 0; s_nwr <= 1; s_pre_nwr <= 1;
      s_early <= 0; s_nostall <= 0; s_both <= 0; s_dat <= 0;
    end else if (!n_dstb || !n_astb) begin
      if (!s_any) s_pre_nwr <= prev_nwr;
      s_any <= 1;
      if (!n_astb) s_a <= 1;
      if (!n_dstb) s_d <= 1;
      if (!n_astb && !n_dstb) s_both <= 1;
      s_oe <= pd_oe; s_nwr <= n_write; s_dat <= pd_out;
      if (!hb_wait) s_nostall <= 1;
      if (n_wait && !acked) s_early <= 1;
      if (!per_hang && acnt >= per_ack) begin n_wait <= 1; acked <= 1; end
      else acnt <= acnt + 1;
    end else if (acked) n_wait <= 0;
    else if (hcnt < per_hold) begin hcnt <= hcnt + 1; n_wait <= 1; end
    else n_wait <= 0;
    prev_nwr <= n_write;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [2:0] a, input bit wr, input logic [7:0] d,
                     output logic [7:0] rd, output int stall);
    repeat (3) @(negedge clk);
    hb_addr = a; hb_wdata = d; hb_wr = wr; hb_rd = !wr;
    #1;
    stall = 0;
    while (hb_wait && stall < 2000) begin
      @(negedge clk); #1;
      if (hb_wait) stall++;
    end
    rd = hb_rdata;
    @(posedge clk); #1;
    hb_wr = 0; hb_rd = 0;
  endtask

  function automatic bit exp_astb(input logic [2:0] a);
    return a == 3'd3;
  endfunction

  function automatic bit exp_wrline(input bit wr, input bit pcd, input bit fstb);
    return (wr && !pcd) || fstb;
  endfunction

  logic [7:0] r;
  int st;

  initial begin : wd
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(n_write && n_dstb && n_astb && !hb_wait && pd_oe, "R1 pins",
        {n_write, n_dstb, n_astb, hb_wait, pd_oe}, 5'b11101);
    chk(strobe_n && autofd_n && init_n, "R1 ctl pins", {strobe_n, autofd_n, init_n}, 3'b111);
    acc(3'd1, 0, 0, r, st); chk(r == 0, "R1 status", r, 0);
    acc(3'd2, 0, 0, r, st); chk(r == 0, "R1 control", r, 0);

    // R2 standard port behaviour
    acc(3'd0, 1, 8'hA5, r, st); chk(pd_out == 8'hA5, "R2 data", pd_out, 8'hA5);
    acc(3'd2, 1, 8'h07, r, st);
    chk({strobe_n, autofd_n, init_n, pd_oe} == 4'b0001, "R2 ctl pins",
        {strobe_n, autofd_n, init_n, pd_oe}, 4'b0001);
    acc(3'd2, 1, 8'h22, r, st);
    chk({strobe_n, autofd_n, init_n, pd_oe} == 4'b1010, "R2 dir",
        {strobe_n, autofd_n, init_n, pd_oe}, 4'b1010);
    per_drive = 8'h3C;
    acc(3'd0, 0, 0, r, st); chk(r == 8'h3C, "R2 pin read", r, 8'h3C);
    acc(3'd2, 0, 0, r, st); chk(r == 8'h22, "R2 ctl read", r, 8'h22);
    acc(3'd2, 1, 8'h00, r, st);

    // directed: hold wait high at start, then slow ack (R3, R5)
    per_hold = 4; per_ack = 5;
    acc(3'd4, 1, 8'h96, r, st);
    chk(!s_early, "R3 wait-before-strobe", s_early, 0);
    chk(s_d && !s_a && s_dat == 8'h96 && s_oe && !s_nwr, "R3 write",
        s_dat, 8'h96);
    chk(!s_pre_nwr, "R3 nwrite leads strobe", s_pre_nwr, 0);
    chk(st >= 5 && !s_nostall, "R5 stall", st, 5);
    per_hold = 0;

    // R4 address port write and read
    per_ack = 2;
    acc(3'd3, 1, 8'h11, r, st);
    chk(s_a && !s_d && s_dat == 8'h11, "R4 addr write", {s_a, s_d}, 2'b10);
    per_drive = 8'hE7;
    acc(3'd3, 0, 0, r, st);
    chk(s_a && !s_d && r == 8'hE7, "R4 addr read", r, 8'hE7);

    // R6 read
    per_drive = 8'h4B;
    acc(3'd6, 0, 0, r, st);
    chk(r == 8'h4B && s_nwr && !s_oe && s_d, "R6 read", r, 8'h4B);

    // random mix
    for (int i = 0; i < 80; i++) begin
      logic [2:0] a;
      bit wr;
      logic [7:0] d;
      a = 3'(3 + $urandom % 5);
      wr = 1'($urandom % 2);
      d = 8'($urandom);
      per_ack = $urandom % 6;
      per_hold = $urandom % 4;
      per_drive = 8'($urandom);
      acc(a, wr, d, r, st);
      chk(s_a == exp_astb(a) && s_d == !exp_astb(a), "R4 strobe select", {s_a, s_d}, {exp_astb(a), !exp_astb(a)});
      chk(!s_nwr == exp_wrline(wr, 0, 0), "R3 write line", s_nwr, !exp_wrline(wr, 0, 0));
      if (wr) chk(s_dat == d, "R3 byte", s_dat, d);
      else    chk(r == per_drive, "R6 byte", r, per_drive);
      chk(!s_early && !s_nostall && !s_both, "R11 R5 handshake", {s_early, s_nostall, s_both}, 0);
    end
    per_hold = 0;
    acc(3'd1, 0, 0, r, st); chk(r == 0, "R7 no timeout", r, 0);

    // R7 watchdog
    per_hang = 1;
    acc(3'd4, 1, 8'h5A, r, st);
    chk(st >= TMO - 2 && st <= TMO + 4, "R7 abort time", st, TMO);
    chk(n_dstb && n_astb, "R7 strobe released", {n_dstb, n_astb}, 2'b11);
    per_hang = 0;
    acc(3'd1, 0, 0, r, st); chk(r[0] == 1, "R7 flag set", r, 1);
    acc(3'd1, 1, 8'hFE, r, st);
    acc(3'd1, 0, 0, r, st); chk(r[0] == 1, "R7 write0 keeps", r, 1);
    acc(3'd1, 1, 8'h01, r, st);
    acc(3'd1, 0, 0, r, st); chk(r[0] == 0, "R7 clear", r, 0);

    // R8 forced write direction
    acc(3'd2, 1, 8'h01, r, st);
    acc(3'd5, 0, 0, r, st);
    chk(!s_nwr && s_oe && s_d, "R8 forced write", {s_nwr, s_oe}, 2'b01);
    acc(3'd2, 1, 8'h00, r, st);

    // R9 direction bit set on write
    acc(3'd0, 1, 8'h5A, r, st);
    acc(3'd2, 1, 8'h20, r, st);
    per_drive = 8'h81;
    acc(3'd5, 1, 8'hC3, r, st);
    chk(s_nwr && !s_oe && s_d, "R9 read-style", {s_nwr, s_oe}, 2'b10);
    acc(3'd2, 1, 8'h00, r, st);
    chk(pd_out == 8'h5A, "R9 data kept", pd_out, 8'h5A);
    acc(3'd1, 0, 0, r, st); chk(r == 0, "R9 no error", r, 0);

    // R10 EPP disabled
    epp_en = 0;
    acc(3'd4, 1, 8'hF0, r, st);
    chk(st == 0 && !s_any, "R10 no cycle", st, 0);
    chk(pd_out == 8'h5A, "R10 no change", pd_out, 8'h5A);
    acc(3'd3, 0, 0, r, st);
    chk(st == 0 && !s_any, "R10 read", st, 0);
    epp_en = 1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule